// File: doc/BRIEF.md
# Prescaled Reloading Real-Time Timer

This block keeps time for a system whose processor may be halted. A 7-bit prescaler and a 16-bit down counter together form a single 23-bit down-counting chain. The chain advances once per selected tick. When the whole chain is at zero, the next tick reloads it from a programmed 16-bit value and sets a sticky overflow flag. That flag can raise an interrupt request, a wake-up request, or both, each under its own enable. Each clock source is modelled as a one-cycle tick enable in the `clk` domain. One tick comes from the CPU clock and one from a crystal oscillator. When the crystal already drives the CPU, the CPU tick is used regardless of the select bit.

Software uses a small register port with four word addresses:

| Address | Name | Access |
|---|---|---|
| 0 | CTRL | read/write |
| 1 | RELOAD | read/write |
| 2 | COUNT | read-only, the 16-bit counter |
| 3 | PRE | read-only, the prescaler, zero-extended |

The CTRL fields are:

| Bit | Meaning |
|---|---|
| 0 | run enable |
| 1 | crystal source select |
| 2 | interrupt enable |
| 3 | wake enable |
| 4 | flag on read; writing 1 clears it |

The block has a single asynchronous active-low power-on reset. No other reset reaches any of its state, so an ordinary system reset leaves the timer running.

A two-state controller sequences the chain:

- `ST_HALT`: the chain is frozen.
- `ST_COUNT`: the chain counts or reloads on each tick.

It has two transitions:

- `HALT_TO_COUNT`: taken on the edge after the enable bit is seen set.
- `COUNT_TO_HALT`: taken on the edge after the enable bit is seen clear.

While in `ST_COUNT`, counting stops at once if the enable bit is cleared.

Top module: `rtt_top`

## Requirements
- R1: After power-on reset (por_n low), CTRL reads 0, RELOAD reads 0xFFFF, COUNT reads 0xFFFF, PRE reads 0x7F, and irq and wake are 0.
- R2: In ST_COUNT with CTRL bit 0 set, each selected tick that finds the chain non-zero decrements the 23-bit value {COUNT,PRE} by one. PRE therefore wraps from 0 to 127 and takes one from COUNT.
- R3: A selected tick that finds COUNT and PRE both zero loads COUNT from RELOAD, sets PRE to 127 and sets the flag (CTRL bit 4).
- R4: The flag stays set until a CTRL write with bit 4 = 1. A CTRL write with bit 4 = 0 does not clear it. A clear write on the same edge as a reload leaves the flag set.
- R5: irq equals flag AND CTRL bit 2. wake equals flag AND CTRL bit 3.
- R6: CTRL bit 1 = 1 selects xtal_tick as the count source. CTRL bit 1 = 0 selects cpu_tick. The unselected tick has no effect.
- R7: While xtal_is_cpu is 1, cpu_tick is the count source and xtal_tick has no effect, whatever CTRL bit 1 holds.
- R8: With CTRL bit 0 clear, ticks do not change COUNT or PRE.
- R9: A RELOAD write while CTRL bit 0 is clear also sets COUNT to the written value and PRE to 127. While bit 0 is set, only RELOAD changes.
- R10: A CTRL write that sets bit 0 on edge P moves the controller HALT_TO_COUNT on edge P+1. The first tick counted is on edge P+2; ticks on edges P and P+1 are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| cpu_tick | input | 1 | One-cycle tick from the CPU clock |
| xtal_tick | input | 1 | One-cycle tick from the crystal oscillator |
| xtal_is_cpu | input | 1 | High when the crystal already drives the CPU |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
The assertions check the following on every cycle:

- the flag holds until a clear;
- the chain is frozen while disabled or halted;
- the crystal source is overridden when it drives the CPU;
- reload-at-zero loads the right value and sets the flag;
- irq and wake never rise without the flag.

The bench scenarios cover what a single-cycle property cannot show:

- the exact reload period of 128 × (RELOAD + 1) ticks;
- the two-edge start latency after enabling;
- a clear that collides with a reload;
- the direct counter load on a disabled reload write;
- the return of every register to its defaults on a second power-on reset in mid-run.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

    localparam int unsigned RTT_PRE_W = 7;
    localparam int unsigned RTT_CNT_W = 16;

    typedef enum logic [1:0] {
        A_CTRL   = 2'd0,
        A_RELOAD = 2'd1,
        A_COUNT  = 2'd2,
        A_PRE    = 2'd3
    } rtt_addr_e;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } rtt_state_e;

    // control bit positions
    localparam int unsigned B_EN    = 0;
    localparam int unsigned B_SRC   = 1;
    localparam int unsigned B_IRQEN = 2;
    localparam int unsigned B_WAKEN = 3;
    localparam int unsigned B_FLAG  = 4;

    typedef struct packed {
        logic wake_en;
        logic irq_en;
        logic src_xtal;
        logic en;
    } rtt_ctrl_t;

endpackage

// File: rtl/rtt_tick_sel.sv
module rtt_tick_sel (
    input  logic cpu_tick,
    input  logic xtal_tick,
    input  logic xtal_is_cpu,
    input  logic src_xtal,
    output logic sel_tick
);

    logic use_xtal;

    always_comb begin
        use_xtal = src_xtal && !xtal_is_cpu;
        sel_tick = use_xtal ? xtal_tick : cpu_tick;
    end

endmodule

// File: rtl/rtt_ctrl.sv
module rtt_ctrl
    import rtt_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       en,
    input  logic       sel_tick,
    input  logic       zero,
    output rtt_state_e state,
    output logic       act_dec,
    output logic       act_reload
);

    rtt_state_e state_nx;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT:  if (en)  state_nx = ST_COUNT;   // HALT_TO_COUNT
            ST_COUNT: if (!en) state_nx = ST_HALT;    // COUNT_TO_HALT
            default:           state_nx = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        act_dec    = 1'b0;
        act_reload = 1'b0;
        unique case (state)
            ST_HALT: begin
                act_dec    = 1'b0;
                act_reload = 1'b0;
            end
            ST_COUNT: begin
                act_dec    = en && sel_tick && !zero;
                act_reload = en && sel_tick && zero;
            end
            default: begin
                act_dec    = 1'b0;
                act_reload = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rtt_chain.sv
module rtt_chain #(
    parameter int unsigned PRE_W = 7,
    parameter int unsigned CNT_W = 16,
    parameter logic [CNT_W-1:0] RELOAD_INIT = '1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             direct_load,
    input  logic [CNT_W-1:0] direct_val,
    input  logic             act_reload,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             act_dec,
    output logic [CNT_W-1:0] cnt,
    output logic [PRE_W-1:0] pre,
    output logic             zero
);

    localparam int unsigned CHAIN_W = PRE_W + CNT_W;

    logic [CHAIN_W-1:0] chain_dec;

    assign chain_dec = {cnt, pre} - CHAIN_W'(1);
    assign zero      = (cnt == '0) && (pre == '0);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= RELOAD_INIT;
            pre <= '1;
        end else if (direct_load) begin
            cnt <= direct_val;
            pre <= '1;
        end else if (act_reload) begin
            cnt <= reload_val;
            pre <= '1;
        end else if (act_dec) begin
            cnt <= chain_dec[CHAIN_W-1:PRE_W];
            pre <= chain_dec[PRE_W-1:0];
        end
    end

endmodule

// File: rtl/rtt_regs.sv
module rtt_regs
    import rtt_pkg::*;
#(
    parameter int unsigned PRE_W = 7,
    parameter int unsigned CNT_W = 16,
    parameter logic [CNT_W-1:0] RELOAD_INIT = '1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    input  logic [PRE_W-1:0] pre,
    output rtt_ctrl_t        ctrl,
    output logic [CNT_W-1:0] reload_val,
    output logic             flag,
    output logic             direct_load,
    output logic [CNT_W-1:0] rd_data
);

    localparam int unsigned PAD_W = CNT_W - PRE_W;

    logic wr_ctrl, wr_reload, flag_clr;

    assign wr_ctrl     = wr_en && (rtt_addr_e'(wr_addr) == A_CTRL);
    assign wr_reload   = wr_en && (rtt_addr_e'(wr_addr) == A_RELOAD);
    assign flag_clr    = wr_ctrl && wr_data[B_FLAG];
    assign direct_load = wr_reload && !ctrl.en;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctrl       <= '0;
            reload_val <= RELOAD_INIT;
        end else begin
            if (wr_ctrl) begin
                ctrl.en       <= wr_data[B_EN];
                ctrl.src_xtal <= wr_data[B_SRC];
                ctrl.irq_en   <= wr_data[B_IRQEN];
                ctrl.wake_en  <= wr_data[B_WAKEN];
            end
            if (wr_reload) reload_val <= wr_data;
        end
    end

    // sticky flag: a wrap wins over a clear
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        flag <= 1'b0;
        else if (wrap)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        unique case (rtt_addr_e'(rd_addr))
            A_CTRL: begin
                rd_data[B_EN]    = ctrl.en;
                rd_data[B_SRC]   = ctrl.src_xtal;
                rd_data[B_IRQEN] = ctrl.irq_en;
                rd_data[B_WAKEN] = ctrl.wake_en;
                rd_data[B_FLAG]  = flag;
            end
            A_RELOAD: rd_data = reload_val;
            A_COUNT:  rd_data = cnt;
            A_PRE:    rd_data = {{PAD_W{1'b0}}, pre};
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/rtt_top.sv
module rtt_top
    import rtt_pkg::*;
#(
    parameter int unsigned PRE_W = RTT_PRE_W,
    parameter int unsigned CNT_W = RTT_CNT_W,
    parameter logic [CNT_W-1:0] RELOAD_INIT = '1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             cpu_tick,
    input  logic             xtal_tick,
    input  logic             xtal_is_cpu,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq,
    output logic             wake
);

    rtt_ctrl_t        ctrl;
    rtt_state_e       state;
    logic             sel_tick, zero, act_dec, act_reload, flag, direct_load;
    logic [CNT_W-1:0] reload_val, cnt;
    logic [PRE_W-1:0] pre;

    rtt_tick_sel u_sel (
        .cpu_tick    (cpu_tick),
        .xtal_tick   (xtal_tick),
        .xtal_is_cpu (xtal_is_cpu),
        .src_xtal    (ctrl.src_xtal),
        .sel_tick    (sel_tick)
    );

    rtt_ctrl u_ctrl (
        .clk        (clk),
        .por_n      (por_n),
        .en         (ctrl.en),
        .sel_tick   (sel_tick),
        .zero       (zero),
        .state      (state),
        .act_dec    (act_dec),
        .act_reload (act_reload)
    );

    rtt_chain #(.PRE_W(PRE_W), .CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT)) u_chain (
        .clk         (clk),
        .por_n       (por_n),
        .direct_load (direct_load),
        .direct_val  (wr_data),
        .act_reload  (act_reload),
        .reload_val  (reload_val),
        .act_dec     (act_dec),
        .cnt         (cnt),
        .pre         (pre),
        .zero        (zero)
    );

    rtt_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT)) u_regs (
        .clk         (clk),
        .por_n       (por_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .wrap        (act_reload),
        .cnt         (cnt),
        .pre         (pre),
        .ctrl        (ctrl),
        .reload_val  (reload_val),
        .flag        (flag),
        .direct_load (direct_load),
        .rd_data     (rd_data)
    );

    assign irq  = flag && ctrl.irq_en;
    assign wake = flag && ctrl.wake_en;

endmodule

// File: rtl/rtt_checks.sv
module rtt_checks
    import rtt_pkg::*;
#(
    parameter int unsigned PRE_W = 7,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             por_n,
    input logic             cpu_tick,
    input logic             xtal_is_cpu,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic             irq,
    input logic             wake,
    input logic             en,
    input logic             sel_tick,
    input rtt_state_e       state,
    input logic             flag,
    input logic             direct_load,
    input logic [CNT_W-1:0] cnt,
    input logic [PRE_W-1:0] pre,
    input logic [CNT_W-1:0] reload_val
);

    logic clr_wr, reload_wr;
    assign clr_wr    = wr_en && (wr_addr == 2'd0) && wr_data[B_FLAG];
    assign reload_wr = wr_en && (wr_addr == 2'd1);

    // R4: flag holds without a clear write
    p_flag_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
        (flag && !clr_wr) |=> flag);

    // R8: disabled chain is frozen apart from a reload write
    p_frozen_r8: assert property (@(posedge clk) disable iff (!por_n)
        (!en && !reload_wr) |=> ($stable(cnt) && $stable(pre)));

    // R10: halted controller never moves the chain
    p_halt_still_r10: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_HALT && !direct_load) |=> ($stable(cnt) && $stable(pre)));

    // R7: crystal-as-CPU forces the CPU tick
    p_xtal_forced_r7: assert property (@(posedge clk) disable iff (!por_n)
        xtal_is_cpu |-> (sel_tick == cpu_tick));

    // R3: tick at zero reloads and sets the flag
    p_reload_r3: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_COUNT && en && sel_tick && cnt == '0 && pre == '0)
        |=> (flag && pre == '1 && cnt == $past(reload_val)));

    // R5: requests only with the flag
    p_irq_flag_r5: assert property (@(posedge clk) disable iff (!por_n)
        irq |-> flag);
    p_wake_flag_r5: assert property (@(posedge clk) disable iff (!por_n)
        wake |-> flag);

endmodule

bind rtt_top rtt_checks #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .cpu_tick    (cpu_tick),
    .xtal_is_cpu (xtal_is_cpu),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .irq         (irq),
    .wake        (wake),
    .en          (ctrl.en),
    .sel_tick    (sel_tick),
    .state       (state),
    .flag        (flag),
    .direct_load (direct_load),
    .cnt         (cnt),
    .pre         (pre),
    .reload_val  (reload_val)
);

// File: tb/tb_rtt_top.sv
`timescale 1ns/1ps
module tb_rtt_top;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        cpu_tick = 1'b0, xtal_tick = 1'b0, xtal_is_cpu = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq, wake;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    rtt_top dut (
        .clk(clk), .por_n(por_n), .cpu_tick(cpu_tick), .xtal_tick(xtal_tick),
        .xtal_is_cpu(xtal_is_cpu), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .wake(wake)
    );

    // sel: 0..3 register address, 4 irq, 5 wake
    typedef struct {
        int          sel;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t q[$];

    // monitor: compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = q.pop_front();
                if (it.sel == 4)      act = {15'b0, irq};
                else if (it.sel == 5) act = {15'b0, wake};
                else                  act = rd_data;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    // all tasks start and end 1 ns after a rising edge
    task automatic expect_val(input int sel, input logic [15:0] exp, input string tag);
        item_t it;
        if (sel < 4) rd_addr = sel[1:0];
        it.sel = sel; it.exp = exp; it.tag = tag;
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n, input logic c, input logic x);
        cpu_tick = c; xtal_tick = x;
        repeat (n) @(posedge clk);
        #1;
        cpu_tick = 1'b0; xtal_tick = 1'b0;
    endtask

    task automatic chain_is(input int m, input string tag);
        expect_val(2, 16'(m >> 7), tag);
        expect_val(3, 16'(m & 127), tag);
    endtask

    task automatic do_por();
        por_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 por_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int m;
        @(posedge clk); #1;
        do_por();

        // R1 defaults
        expect_val(0, 16'h0000, "R1 ctrl");
        expect_val(1, 16'hFFFF, "R1 reload");
        chain_is(23'h7FFFFF, "R1 chain");
        expect_val(4, 16'h0, "R1 irq");
        expect_val(5, 16'h0, "R1 wake");

        // R8 disabled ignores ticks
        ticks(20, 1'b1, 1'b1);
        chain_is(23'h7FFFFF, "R8 frozen");

        // R9 reload write while disabled loads the chain
        wr(2'd1, 16'd2);
        expect_val(1, 16'd2, "R9 reload");
        chain_is(2 * 128 + 127, "R9 direct load");

        // R10 enable latency: ticks on write edge and the next are ignored
        cpu_tick = 1'b1;
        wr(2'd0, 16'h0005);
        @(posedge clk); #1;
        cpu_tick = 1'b0;
        chain_is(383, "R10 no count yet");
        ticks(1, 1'b1, 1'b0);
        m = 382;
        chain_is(m, "R10 first tick");

        // R2 decrement through prescaler wraps
        ticks(100, 1'b1, 1'b0); m -= 100;
        chain_is(m, "R2 mid");
        ticks(282, 1'b1, 1'b0); m = 0;
        chain_is(m, "R2 zero");
        expect_val(0, 16'h0005, "R2 no flag at zero");

        // R3 reload and flag
        ticks(1, 1'b1, 1'b0); m = 383;
        chain_is(m, "R3 reload");
        expect_val(0, 16'h0015, "R3 flag");
        expect_val(4, 16'h1, "R5 irq");
        expect_val(5, 16'h0, "R5 wake off");

        // R4 sticky flag
        wr(2'd0, 16'h0005);
        expect_val(0, 16'h0015, "R4 write 0 keeps flag");
        wr(2'd0, 16'h0015);
        expect_val(0, 16'h0005, "R4 clear");
        expect_val(4, 16'h0, "R5 irq after clear");

        // R4 clear colliding with reload
        ticks(383, 1'b1, 1'b0);
        chain_is(0, "R4 at zero");
        cpu_tick = 1'b1;
        wr(2'd0, 16'h0015);
        cpu_tick = 1'b0;
        expect_val(0, 16'h0015, "R4 reload beats clear");
        chain_is(383, "R4 reloaded");
        wr(2'd0, 16'h0015);

        // R5 wake path only
        wr(2'd0, 16'h0009);
        ticks(384, 1'b1, 1'b0); m = 383;
        expect_val(5, 16'h1, "R5 wake");
        expect_val(4, 16'h0, "R5 irq disabled");
        wr(2'd0, 16'h0019);
        expect_val(0, 16'h0009, "R4 clear again");

        // R6 crystal source
        wr(2'd0, 16'h000B);
        ticks(10, 1'b1, 1'b0);
        chain_is(m, "R6 cpu tick ignored");
        ticks(10, 1'b0, 1'b1); m -= 10;
        chain_is(m, "R6 xtal counts");

        // R7 crystal is CPU clock
        xtal_is_cpu = 1'b1;
        ticks(10, 1'b0, 1'b1);
        chain_is(m, "R7 xtal ignored");
        ticks(5, 1'b1, 1'b0); m -= 5;
        chain_is(m, "R7 cpu counts");
        xtal_is_cpu = 1'b0;

        // R9 reload write while enabled
        wr(2'd1, 16'd9);
        expect_val(1, 16'd9, "R9 reload enabled");
        chain_is(m, "R9 no direct load");

        // R8 disable freezes
        wr(2'd0, 16'h0000);
        ticks(50, 1'b1, 1'b1);
        chain_is(m, "R8 frozen after disable");
        wr(2'd1, 16'd4);
        chain_is(4 * 128 + 127, "R9 direct load again");

        // R1 power-on reset mid-run
        wr(2'd0, 16'h0005);
        ticks(30, 1'b1, 1'b0);
        do_por();
        expect_val(0, 16'h0000, "R1 ctrl after por");
        expect_val(1, 16'hFFFF, "R1 reload after por");
        chain_is(23'h7FFFFF, "R1 chain after por");

        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule